// File: doc/BRIEF.md
# Debug Shadow Scan Chain with Decoder Override

This block sits beside a small CPU and gives an external host serial access to the CPU's state. A 64-bit shadow chain moves one bit per rising edge of the host's serial clock. Bits enter on the serial input and leave on the serial output. After each CPU clock, the chain can take a parallel snapshot of the CPU registers (R0 to R3, the program counter and the 16-bit instruction register). The host can then read that snapshot out with a full scan.

The top eight bits of the chain form a control byte, which the CPU never overwrites. The host uses two of its bits. One makes the instruction decoder read the shadow instruction instead of the real one, so the host can inject instructions. The other forces the decoder's load enables inactive and has the real instruction register load from the shadow.

The serial clock, the CPU clock and the serial data are sampled by the block's fast system clock through synchronizers. Every action happens on a detected edge of those slow signals.

Top module: `dbg_shadow_scan`

## Requirements
- R1: After the active-low asynchronous reset, the whole chain reads zero, the serial output is 0 and the control byte is zero. The decoder then sees the CPU's own instruction register and unchanged load enables, and the instruction-register load request is 0.
- R2: On a rising serial-clock edge with no capture armed, the chain shifts one place toward the serial output and takes the serial input into its least significant bit. The serial output always shows the chain's most significant bit. A host that samples the output before each of 64 rising edges therefore reads back the previous chain contents, most significant bit first.
- R3: The chain layout, from the serial-output end, is control byte (bits 63:56), R0 (55:48), R1 (47:40), R2 (39:32), R3 (31:24), PC (23:16), then the instruction-register shadow (15:0).
- R4: A falling CPU-clock edge arms a capture. The next rising serial-clock edge then loads every CPU register field in parallel instead of shifting, and leaves the control byte unchanged.
- R5: The armed capture is withdrawn on the first falling serial-clock edge after the load. Later rising edges shift normally.
- R6: A falling serial-clock edge that comes after arming but before any load does not withdraw the capture.
- R7: When control bit 1 (chain bit 57) is set, the decoder instruction output carries the 16-bit shadow. Otherwise it carries the CPU's instruction register.
- R8: When control bit 2 (chain bit 58) is set, all decoder load-enable outputs are 0, the instruction-register load request is 1, and the load data equals the 16-bit shadow. When the bit is clear, the load enables pass through unchanged and the request is 0.
- R9: When a falling CPU-clock edge arrives in the same cycle as the falling serial-clock edge that would withdraw a capture, the capture stays armed. The next rising serial-clock edge loads again.
- R10: Without rising serial-clock edges, the chain, and with it the control byte and the instruction shadow, keeps its value across any number of CPU clocks. The override stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all slow inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock |
| mosi_i | input | 1 | Host serial data into the chain |
| miso_o | output | 1 | Chain serial data to the host (chain MSB) |
| cpu_clk_i | input | 1 | CPU clock, whose falling edge arms a capture |
| r0_i | input | 8 | CPU register R0 |
| r1_i | input | 8 | CPU register R1 |
| r2_i | input | 8 | CPU register R2 |
| r3_i | input | 8 | CPU register R3 |
| pc_i | input | 8 | CPU program counter |
| ir_i | input | 16 | CPU instruction register |
| dec_le_i | input | 4 | Load enables produced by the CPU decoder |
| dec_ir_o | output | 16 | Instruction presented to the decoder |
| dec_le_o | output | 4 | Load enables after gating |
| ir_load_o | output | 1 | Request that the real instruction register load from the shadow |
| ir_data_o | output | 16 | Data for that load (the shadow) |

## Verification
Two events can collide in one system-clock cycle: the re-arming of a capture by a falling CPU clock, and the withdrawal of a capture by a falling serial clock after a load. The bench provokes this by dropping both inputs on the same edge, right after a load, and then changes the CPU register values. It then gives one more rising serial clock and scans out. The scan must show the second set of values. If the withdrawal had won, the chain would instead hold the first snapshot shifted by one place.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int CTRL_TAKEOVER_BIT = 1;
  localparam int CTRL_IRWR_BIT     = 2;

  typedef struct packed {
    logic ir_write;
    logic takeover;
  } ovr_t;
endpackage

// File: rtl/dbg_sync_edge.sv
module dbg_sync_edge #(
  parameter int CW     = 2,
  parameter int DW     = 1,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] clk_async_i,
  input  logic [DW-1:0] data_async_i,
  output logic [CW-1:0] rise_o,
  output logic [CW-1:0] fall_o,
  output logic [DW-1:0] data_o
);
  for (genvar g = 0; g < CW; g++) begin : g_clk
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], clk_async_i[g]};
    end
    assign rise_o[g] =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[g] = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
  end

  // data delayed to line up with the detected edges
  for (genvar g = 0; g < DW; g++) begin : g_dat
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], data_async_i[g]};
    end
    assign data_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain #(
  parameter int CTRL_W = 8,
  parameter int CAP_W  = 56,
  localparam int CHW   = CTRL_W + CAP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             sclk_fall_i,
  input  logic             arm_i,
  input  logic             ser_i,
  input  logic [CAP_W-1:0] cap_i,
  output logic [CHW-1:0]   chain_o
);
  logic [CHW-1:0] chain_q;
  logic           arm_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else if (shift_i) begin
      if (arm_q) chain_q <= {chain_q[CHW-1 -: CTRL_W], cap_i};
      else       chain_q <= {chain_q[CHW-2:0], ser_i};
    end
  end

  // a fresh CPU edge beats the withdrawal in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (arm_i) begin
      arm_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (shift_i && arm_q) begin
      done_q <= 1'b1;
    end else if (sclk_fall_i && done_q) begin
      arm_q  <= 1'b0;
      done_q <= 1'b0;
    end
  end

  assign chain_o = chain_q;

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !arm_q) |=> chain_q[CHW-1:1] == $past(chain_q[CHW-2:0]));
  p_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> arm_q);
  p_ctrl_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && arm_q) |=> $stable(chain_q[CHW-1 -: CTRL_W]));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && done_q && !arm_i) |=> !arm_q);
  p_early_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q && !done_q && sclk_fall_i) |=> arm_q);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(chain_q));
endmodule

// File: rtl/dbg_decode_ovr.sv
module dbg_decode_ovr
  import dbg_scan_pkg::*;
#(
  parameter int IR_W = 16,
  parameter int LE_W = 4
) (
  input  ovr_t            ovr_i,
  input  logic [IR_W-1:0] shadow_ir_i,
  input  logic [IR_W-1:0] cpu_ir_i,
  input  logic [LE_W-1:0] dec_le_i,
  output logic [IR_W-1:0] dec_ir_o,
  output logic [LE_W-1:0] dec_le_o,
  output logic            ir_load_o,
  output logic [IR_W-1:0] ir_data_o
);
  assign dec_ir_o  = ovr_i.takeover ? shadow_ir_i : cpu_ir_i;
  assign dec_le_o  = ovr_i.ir_write ? '0 : dec_le_i;
  assign ir_load_o = ovr_i.ir_write;
  assign ir_data_o = shadow_ir_i;

  always_comb begin
    p_gate_r8: assert (!(ir_load_o && (dec_le_o != '0)));
  end
endmodule

// File: rtl/dbg_shadow_scan.sv
module dbg_shadow_scan
  import dbg_scan_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int IR_W        = 16,
  parameter int LE_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            mosi_i,
  output logic            miso_o,
  input  logic            cpu_clk_i,
  input  logic [REG_W-1:0] r0_i,
  input  logic [REG_W-1:0] r1_i,
  input  logic [REG_W-1:0] r2_i,
  input  logic [REG_W-1:0] r3_i,
  input  logic [REG_W-1:0] pc_i,
  input  logic [IR_W-1:0] ir_i,
  input  logic [LE_W-1:0] dec_le_i,
  output logic [IR_W-1:0] dec_ir_o,
  output logic [LE_W-1:0] dec_le_o,
  output logic            ir_load_o,
  output logic [IR_W-1:0] ir_data_o
);
  localparam int CAP_W = 5 * REG_W + IR_W;
  localparam int CHW   = REG_W + CAP_W;
  localparam int I_SCLK = 0;
  localparam int I_CPU  = 1;

  logic [1:0]       rise, fall;
  logic             mosi_s;
  logic [CHW-1:0]   chain;
  logic [REG_W-1:0] ctrl;
  ovr_t             ovr;

  dbg_sync_edge #(.CW(2), .DW(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clk_async_i  ({cpu_clk_i, sclk_i}),
    .data_async_i (mosi_i),
    .rise_o       (rise),
    .fall_o       (fall),
    .data_o       (mosi_s)
  );

  dbg_scan_chain #(.CTRL_W(REG_W), .CAP_W(CAP_W)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (rise[I_SCLK]),
    .sclk_fall_i (fall[I_SCLK]),
    .arm_i       (fall[I_CPU]),
    .ser_i       (mosi_s),
    .cap_i       ({r0_i, r1_i, r2_i, r3_i, pc_i, ir_i}),
    .chain_o     (chain)
  );

  assign ctrl         = chain[CHW-1 -: REG_W];
  assign ovr.takeover = ctrl[CTRL_TAKEOVER_BIT];
  assign ovr.ir_write = ctrl[CTRL_IRWR_BIT];
  assign miso_o       = chain[CHW-1];

  dbg_decode_ovr #(.IR_W(IR_W), .LE_W(LE_W)) u_ovr (
    .ovr_i       (ovr),
    .shadow_ir_i (chain[IR_W-1:0]),
    .cpu_ir_i    (ir_i),
    .dec_le_i    (dec_le_i),
    .dec_ir_o    (dec_ir_o),
    .dec_le_o    (dec_le_o),
    .ir_load_o   (ir_load_o),
    .ir_data_o   (ir_data_o)
  );

  p_rise_fall_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise[I_SCLK] && fall[I_SCLK]));
  p_miso_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[I_CPU] |=> $stable(miso_o));
endmodule

// File: tb/dbg_shadow_scan_bench.sv
module dbg_shadow_scan_bench;
  localparam int HOLD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cpu_clk = 1'b0;
  logic [7:0] r0 = '0, r1 = '0, r2 = '0, r3 = '0, pc = '0;
  logic [15:0] ir = '0;
  logic [3:0] dle = 4'b1011;
  logic miso, ir_load;
  logic [15:0] dec_ir, ir_data;
  logic [3:0] dec_le;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbg_shadow_scan u_dbg_shadow_scan (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso),
    .cpu_clk_i(cpu_clk), .r0_i(r0), .r1_i(r1), .r2_i(r2), .r3_i(r3), .pc_i(pc),
    .ir_i(ir), .dec_le_i(dle), .dec_ir_o(dec_ir), .dec_le_o(dec_le),
    .ir_load_o(ir_load), .ir_data_o(ir_data)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; step(HOLD); sclk = 1'b0; step(HOLD);
  endtask

  task automatic cpu_pulse();
    cpu_clk = 1'b1; step(HOLD); cpu_clk = 1'b0; step(HOLD);
  endtask

  task automatic scan(input logic [63:0] tx, output logic [63:0] rx);
    for (int i = 63; i >= 0; i--) begin
      mosi = tx[i]; step(HOLD);
      rx[i] = miso;
      sclk_pulse();
    end
    mosi = 1'b0;
  endtask

  function automatic logic [55:0] cap();
    return {r0, r1, r2, r3, pc, ir};
  endfunction

  task automatic t_reset();
    check("R1 miso", {63'd0, miso}, 64'd0);
    check("R1 dec_ir", {48'd0, dec_ir}, {48'd0, ir});
    check("R1 dec_le", {60'd0, dec_le}, {60'd0, dle});
    check("R1 ir_load", {63'd0, ir_load}, 64'd0);
  endtask

  task automatic t_shift();
    logic [63:0] rx;
    scan(64'h00A5_3C96_0F1E_2D4B, rx);
    check("R1 chain zero after reset", rx, 64'd0);
    scan(64'h0055_AA01_8000_7FFE, rx);
    check("R2 round trip", rx, 64'h00A5_3C96_0F1E_2D4B);
  endtask

  task automatic t_capture();
    logic [63:0] rx;
    scan(64'h8100_0000_0000_0000, rx);
    r0 = 8'h11; r1 = 8'h22; r2 = 8'h33; r3 = 8'h44; pc = 8'h55; ir = 16'h6677;
    cpu_pulse();
    sclk_pulse();
    scan(64'd0, rx);
    check("R3 layout", rx, 64'h8111_2233_4455_6677);
    check("R4 ctrl kept", {56'd0, rx[63:56]}, 64'h81);
    check("R5 shifts after load", {8'd0, rx[55:0]}, {8'd0, cap()});
  endtask

  task automatic t_early_fall();
    logic [63:0] rx, x;
    x = 64'h4B80_1234_5678_9ABC;
    scan(x, rx);
    mosi = 1'b0;
    sclk = 1'b1; step(HOLD);
    r0 = 8'hA1; r1 = 8'hB2; r2 = 8'hC3; r3 = 8'hD4; pc = 8'hE5; ir = 16'hF00F;
    cpu_pulse();
    sclk = 1'b0; step(HOLD);
    sclk = 1'b1; step(HOLD);
    sclk = 1'b0; step(HOLD);
    scan(64'd0, rx);
    check("R6 early fall keeps arm", rx, {x[62:55], cap()});
  endtask

  task automatic t_collide();
    logic [63:0] rx;
    scan(64'h3000_0000_0000_0000, rx);
    r0 = 8'h01; r1 = 8'h02; r2 = 8'h03; r3 = 8'h04; pc = 8'h05; ir = 16'h0607;
    cpu_pulse();
    sclk = 1'b1; step(HOLD);
    cpu_clk = 1'b1; step(HOLD);
    r0 = 8'h90; r1 = 8'h81; r2 = 8'h72; r3 = 8'h63; pc = 8'h54; ir = 16'h4536;
    sclk = 1'b0; cpu_clk = 1'b0; step(HOLD);
    sclk_pulse();
    scan(64'd0, rx);
    check("R9 collision rearms", rx, {8'h30, cap()});
  endtask

  task automatic t_override();
    logic [63:0] rx;
    ir = 16'hABCD;
    scan(64'h0200_0000_0000_1234, rx);
    check("R7 shadow to decoder", {48'd0, dec_ir}, 64'h1234);
    check("R8 le pass when clear", {60'd0, dec_le}, {60'd0, dle});
    check("R8 no load when clear", {63'd0, ir_load}, 64'd0);
    scan(64'h0400_0000_0000_5678, rx);
    check("R7 cpu ir when clear", {48'd0, dec_ir}, 64'hABCD);
    check("R8 le gated", {60'd0, dec_le}, 64'd0);
    check("R8 load req", {63'd0, ir_load}, 64'd1);
    check("R8 load data", {48'd0, ir_data}, 64'h5678);
  endtask

  task automatic t_hold();
    logic [63:0] rx;
    scan(64'h0600_0000_0000_9ABC, rx);
    for (int k = 0; k < 3; k++) begin
      ir = 16'h1000 + 16'(k);
      cpu_pulse();
      step(20);
      check("R10 decoder ir held", {48'd0, dec_ir}, 64'h9ABC);
      check("R10 load data held", {48'd0, ir_data}, 64'h9ABC);
    end
    check("R10 gate held", {60'd0, dec_le}, 64'd0);
    sclk_pulse();
    check("R4 shadow loaded from cpu", {48'd0, dec_ir}, {48'd0, ir});
    check("R4 ctrl survives load", {63'd0, ir_load}, 64'd1);
    scan(64'd0, rx);
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_shift();
    t_capture();
    t_early_fall();
    t_collide();
    t_override();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule